// File: doc/BRIEF.md
# Card Socket Status-Change Interrupt Controller

This block watches the signal lines of one removable-card socket and turns their changes into host interrupts. It takes the two card-detect lines, four shared card pins whose meaning depends on the interface mode, a wait line, a power-good line and a synchronous access-timeout pulse. Every asynchronous line passes through a two-stage synchroniser. An enabled toggle then latches a sticky pending flag. Software reads the live levels and the pending flags through a 16-bit status register and clears a flag by writing a one to it.

The four shared pins carry the ready, write-protect and two battery-voltage-detect signals when the socket runs in memory-only mode. In memory-plus-I/O mode the same pins carry the I/O request, the 16-bit-I/O indication, the status-change line and the speaker line. In that mode a falling edge on the ready/request pin posts a card I/O interrupt. Two summaries are formed: one over the status-change flags and one for the card I/O interrupt. Each summary has its own one-bit choice of which of the two host interrupt outputs it drives.

Top module: `card_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, every pending flag is 0 and both `irq_o` lines are low.
- R2: The status register (`host_addr`=1) shows live synchronised levels, visible at most three clocks after an input change: bit 7 = `card_det_i[1]`, bit 6 = `card_det_i[0]`, bits 5..2 = `card_pin_i[3:0]`, bit 1 = `card_wait_i`, bit 0 = `card_pwr_i`.
- R3: A toggle of either card-detect line sets pending bit 13 when control bit 9 is 1. When control bit 9 is 0 the toggle sets nothing.
- R4: In memory-only mode (control bit 0 = 0), a toggle of `card_pin_i[3]`, `[2]`, `[1]` or `[0]` sets pending bit 12, 11, 10 or 9 respectively. The enables are control bits 8, 7, 6 and 5. In I/O mode these pin toggles set nothing.
- R5: An `acc_timeout_i` pulse sampled high at a clock edge sets pending bit 8 when control bit 4 is 1, and sets nothing when control bit 4 is 0.
- R6: In I/O mode (control bit 0 = 1) with control bit 3 set, a falling edge of `card_pin_i[1]` sets the card I/O interrupt flag, shown as status bit 15. In memory-only mode status bit 15 reads 0 and the I/O interrupt drives no output.
- R7: A host write to the status register clears each pending bit (15, 13..8) written as 1. A bit written as 0 keeps its value.
- R8: When a set event and a write-one-to-clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Status bit 14 is the OR of pending bits 13..8 that have their enable set. It is read-only.
- R10: The status-change summary drives `irq_o[0]` when control bit 1 = 0 and `irq_o[1]` when it is 1.
- R11: The I/O interrupt summary drives `irq_o[0]` when control bit 2 = 0 and `irq_o[1]` when it is 1, independently of control bit 1. Both outputs can be high at once.
- R12: Control register bits 9..0 are writable and read back. Bits 15..10 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_det_i | input | 2 | Card-detect lines, asynchronous |
| card_pin_i | input | 4 | Shared mode-dependent card pins, asynchronous |
| card_wait_i | input | 1 | Card wait line, asynchronous |
| card_pwr_i | input | 1 | Socket power-good level, asynchronous |
| acc_timeout_i | input | 1 | One-cycle access-timeout pulse, synchronous |
| host_addr | input | 1 | Register select: 0 control, 1 status |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the selected register |
| irq_o | output | 2 | Host interrupt outputs |

## Verification
A flag can be set by a new event in the same cycle that software clears it with a write-one-to-clear. The bench provokes this on the access-timeout flag, because that source is synchronous: it raises the timeout pulse and the status write in the same cycle, so both land on the same clock edge. The flag must read back as still pending afterwards. A second clear with no event present must then empty it. Routing gets a similar collision test: a status-change event and a card I/O interrupt are left pending at the same time, with opposite route bits, and both outputs must be high together.

// File: rtl/card_irq_pkg.sv
// Package: shared widths, control-register layout and status bit positions
// for the card socket interrupt controller.
package card_irq_pkg;
    localparam int REG_W     = 16;  // host register width
    localparam int NUM_CHG   = 6;   // change sources: cd, pin3..pin0, timeout
    localparam int NUM_FLAG  = NUM_CHG + 1;  // plus the card I/O interrupt
    localparam int LIVE_W    = 8;   // live status byte
    localparam int NUM_IRQ   = 2;   // host interrupt outputs
    localparam int PIN_W     = 4;   // shared mode-dependent pins
    localparam int RDY_LIVE  = 3;   // live index of the ready/request pin

    // Control register, packed LSB last: bit 0 io_mode ... bits 9..4 chg_en
    typedef struct packed {
        logic [NUM_CHG-1:0] chg_en;    // [5]=cd [4..1]=pin3..pin0 [0]=timeout
        logic               io_en;     // card I/O interrupt enable
        logic               io_route;  // I/O summary output select
        logic               sc_route;  // status-change summary output select
        logic               io_mode;   // 0 memory-only, 1 memory plus I/O
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/card_sync.sv
// Module: card_sync
// Brings WIDTH asynchronous lines into the clock domain through STAGES
// flops and reports, per line, the synchronised level and a one-cycle toggle
// strobe. Assumes STAGES >= 2 and that inputs are held low during reset.
module card_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] toggle_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    // Synchroniser chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
            prev_q <= '0;
        end else begin
            pipe_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            prev_q <= pipe_q[STAGES-1];
        end
    end

    // Level and toggle outputs from the last stage.
    always_comb begin
        level_o  = pipe_q[STAGES-1];
        toggle_o = pipe_q[STAGES-1] ^ prev_q;
    end
endmodule

// File: rtl/card_flag_bank.sv
// Module: card_flag_bank
// WIDTH sticky pending flags. A set strobe raises a flag, a clear strobe
// lowers it, and set wins when both hit one flag in the same cycle.
// Assumes set_i and clr_i are single-cycle, synchronous strobes.
module card_flag_bank #(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_flag
            // One sticky flag: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)         flags_o[g] <= 1'b0;
                else if (set_i[g])  flags_o[g] <= 1'b1;
                else if (clr_i[g])  flags_o[g] <= 1'b0;
            end
        end
    endgenerate

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i))); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0)); // R7
    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0)); // R3
endmodule

// File: rtl/card_irq_route.sv
// Module: card_irq_route
// Steers the status-change and I/O summaries onto NUM_OUT host lines, each
// summary by its own select. Assumes NUM_OUT is 2 (one-bit selects).
module card_irq_route #(
    parameter int NUM_OUT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sc_sum_i,
    input  logic               io_sum_i,
    input  logic               sc_route_i,
    input  logic               io_route_i,
    output logic [NUM_OUT-1:0] irq_o
);
    genvar k;
    generate
        for (k = 0; k < NUM_OUT; k++) begin : g_line
            localparam logic SEL = (k != 0);
            // Line k is high when any summary routed to it is active.
            always_comb begin
                irq_o[k] = (sc_sum_i && (sc_route_i == SEL)) ||
                           (io_sum_i && (io_route_i == SEL));
            end
        end
    endgenerate

    AST_SC_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_sum_i && !io_sum_i) |-> ($countones(irq_o) == 1)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sc_sum_i && !io_sum_i) |-> (irq_o == '0)); // R11
endmodule

// File: rtl/card_irq_ctrl.sv
// Module: card_irq_ctrl (top)
// Per-socket status-change interrupt controller. It synchronises the card
// lines, detects enabled changes, holds sticky flags that software clears
// by writing ones, forms the two summaries and routes them to the host lines.
// Assumes a one-cycle host write strobe and a combinational read port.
module card_irq_ctrl
    import card_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         card_det_i,
    input  logic [PIN_W-1:0]   card_pin_i,
    input  logic               card_wait_i,
    input  logic               card_pwr_i,
    input  logic               acc_timeout_i,
    input  logic               host_addr,
    input  logic               host_wr,
    input  logic [REG_W-1:0]   host_wdata,
    output logic [REG_W-1:0]   host_rdata,
    output logic [NUM_IRQ-1:0] irq_o
);
    ctrl_t               ctrl_q;
    logic [LIVE_W-1:0]   live;
    logic [LIVE_W-1:0]   tog;
    logic [NUM_FLAG-1:0] set_v;
    logic [NUM_FLAG-1:0] clr_v;
    logic [NUM_FLAG-1:0] flags;
    logic [NUM_CHG-1:0]  chg_set;
    logic                io_set;
    logic                sc_sum;
    logic                io_sum;
    logic                io_vis;
    logic                unused_wbit;

    assign unused_wbit = host_wdata[14];

    card_sync #(.WIDTH(LIVE_W), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  ({card_det_i, card_pin_i, card_wait_i, card_pwr_i}),
        .level_o  (live),
        .toggle_o (tog)
    );

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ctrl_q <= '0;
        else if (host_wr && !host_addr) ctrl_q <= ctrl_t'(host_wdata[CTRL_W-1:0]);
    end

    // Set and clear strobes for the flag bank.
    always_comb begin
        chg_set[5]   = (|tog[7:6]) && ctrl_q.chg_en[5];
        chg_set[4:1] = tog[5:2] & ctrl_q.chg_en[4:1] & {PIN_W{~ctrl_q.io_mode}};
        chg_set[0]   = acc_timeout_i && ctrl_q.chg_en[0];
        io_set       = ctrl_q.io_mode && ctrl_q.io_en &&
                       tog[RDY_LIVE] && !live[RDY_LIVE];
        set_v        = {io_set, chg_set};
        clr_v        = (host_wr && host_addr) ?
                       {host_wdata[15], host_wdata[13:8]} : '0;
    end

    card_flag_bank #(.WIDTH(NUM_FLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .flags_o (flags)
    );

    // Summaries and the mode-masked I/O bit.
    always_comb begin
        sc_sum = |(flags[NUM_CHG-1:0] & ctrl_q.chg_en);
        io_vis = flags[NUM_CHG] && ctrl_q.io_mode;
        io_sum = io_vis && ctrl_q.io_en;
    end

    card_irq_route #(.NUM_OUT(NUM_IRQ)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .sc_sum_i   (sc_sum),
        .io_sum_i   (io_sum),
        .sc_route_i (ctrl_q.sc_route),
        .io_route_i (ctrl_q.io_route),
        .irq_o      (irq_o)
    );

    // Read mux of the two host registers.
    always_comb begin
        if (host_addr) host_rdata = {io_vis, sc_sum, flags[NUM_CHG-1:0], live};
        else           host_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
    end

    AST_MEM_MODE_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.io_mode) |=> !$rose(flags[NUM_CHG])); // R6
    AST_IO_MODE_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.io_mode && !host_wr) |=> ((flags[4:1] & ~$past(flags[4:1])) == '0)); // R4
endmodule

// File: tb/card_irq_ctrl_tb.sv
module card_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  card_det_i = '0;
    logic [3:0]  card_pin_i = '0;
    logic        card_wait_i = 1'b0;
    logic        card_pwr_i = 1'b0;
    logic        acc_timeout_i = 1'b0;
    logic        host_addr = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [1:0]  irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    card_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .card_det_i(card_det_i), .card_pin_i(card_pin_i),
        .card_wait_i(card_wait_i), .card_pwr_i(card_pwr_i), .acc_timeout_i(acc_timeout_i),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_o(irq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_wdata = '0;
    endtask

    task automatic chk_reg(input logic a, input logic [15:0] exp, input string tag);
        host_addr = a;
        #1;
        n_chk++;
        if (host_rdata !== exp) begin
            n_err++;
            $display("FAIL %s: reg%0d got %h expected %h", tag, a, host_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        n_chk++;
        if (irq_o !== exp) begin
            n_err++;
            $display("FAIL %s: irq got %b expected %b", tag, irq_o, exp);
        end
    endtask

    task automatic t_reset;
        chk_reg(1'b0, 16'h0000, "R1");
        chk_reg(1'b1, 16'h0000, "R1");
        chk_irq(2'b00, "R1");
    endtask

    task automatic t_live_and_ctrl;
        @(negedge clk);
        card_det_i = 2'b10; card_pin_i = 4'b1010; card_wait_i = 1'b1; card_pwr_i = 1'b1;
        tick(4);
        chk_reg(1'b1, 16'h00AB, "R2");  // no enables: no flags (R3 disabled)
        chk_irq(2'b00, "R3");
        @(negedge clk);
        card_det_i = 2'b00; card_pin_i = 4'b0000; card_wait_i = 1'b0; card_pwr_i = 1'b0;
        tick(4);
        chk_reg(1'b1, 16'h0000, "R3");
        wr(1'b0, 16'hFFFF);
        chk_reg(1'b0, 16'h03FF, "R12");
        wr(1'b0, 16'h0000);
        chk_reg(1'b0, 16'h0000, "R12");
    endtask

    task automatic t_card_detect;
        wr(1'b0, 16'h0200);  // cd enable, sc route 0
        @(negedge clk); card_det_i = 2'b01;
        tick(4);
        chk_reg(1'b1, 16'h6040, "R3");
        chk_irq(2'b01, "R10");
        wr(1'b1, 16'h2000);
        chk_reg(1'b1, 16'h0040, "R7");
        chk_irq(2'b00, "R7");
        @(negedge clk); card_det_i = 2'b00;
        tick(4);
        chk_reg(1'b1, 16'h6000, "R3");
        wr(1'b1, 16'h2000);
        chk_reg(1'b1, 16'h0000, "R7");
    endtask

    task automatic t_mem_pins;
        wr(1'b0, 16'h01E2);  // pin enables, sc route 1, memory-only
        @(negedge clk); card_pin_i = 4'b0101;
        tick(4);
        chk_reg(1'b1, 16'h4A14, "R4");
        chk_irq(2'b10, "R10");
        wr(1'b1, 16'h0800);
        chk_reg(1'b1, 16'h4214, "R7");
        wr(1'b1, 16'h0000);
        chk_reg(1'b1, 16'h4214, "R7");  // zeros leave flags alone
        wr(1'b1, 16'h0200);
        chk_reg(1'b1, 16'h0014, "R9");
        chk_irq(2'b00, "R9");
        @(negedge clk); card_pin_i = 4'b0000;
        tick(4);
        chk_reg(1'b1, 16'h4A00, "R4");
        wr(1'b0, 16'h0002);  // enables off: flags stay, summary drops
        chk_reg(1'b1, 16'h0A00, "R9");
        chk_irq(2'b00, "R9");
        wr(1'b1, 16'hFF00);
        chk_reg(1'b1, 16'h0000, "R7");
        wr(1'b0, 16'h0000);
    endtask

    task automatic t_io_mode;
        wr(1'b0, 16'h01ED);  // io mode, io en, io route 1, pin enables
        @(negedge clk); card_pin_i = 4'b0010;
        tick(4);
        chk_reg(1'b1, 16'h0008, "R4");  // pin toggle ignored, rising edge no irq
        @(negedge clk); card_pin_i = 4'b0000;
        tick(4);
        chk_reg(1'b1, 16'h8000, "R6");
        chk_irq(2'b10, "R11");
        wr(1'b0, 16'h01EC);  // memory-only
        chk_reg(1'b1, 16'h0000, "R6");
        chk_irq(2'b00, "R6");
        wr(1'b0, 16'h03ED);  // back to io mode plus cd enable, sc route 0
        chk_reg(1'b1, 16'h8000, "R6");
        @(negedge clk); card_det_i = 2'b01;
        tick(4);
        chk_reg(1'b1, 16'hE040, "R11");
        chk_irq(2'b11, "R11");
        wr(1'b1, 16'hA000);
        chk_reg(1'b1, 16'h0040, "R7");
        chk_irq(2'b00, "R7");
        @(negedge clk); card_det_i = 2'b00;
        tick(4);
        wr(1'b1, 16'h2000);
        chk_reg(1'b1, 16'h0000, "R7");
        wr(1'b0, 16'h0000);
    endtask

    task automatic t_timeout_collision;
        @(negedge clk); acc_timeout_i = 1'b1;
        @(negedge clk); acc_timeout_i = 1'b0;
        tick(1);
        chk_reg(1'b1, 16'h0000, "R5");  // disabled
        wr(1'b0, 16'h0010);
        @(negedge clk); acc_timeout_i = 1'b1;
        @(negedge clk); acc_timeout_i = 1'b0;
        tick(1);
        chk_reg(1'b1, 16'h4100, "R5");
        chk_irq(2'b01, "R10");
        @(negedge clk);
        acc_timeout_i = 1'b1; host_addr = 1'b1; host_wdata = 16'h0100; host_wr = 1'b1;
        @(negedge clk);
        acc_timeout_i = 1'b0; host_wr = 1'b0; host_wdata = '0;
        tick(1);
        chk_reg(1'b1, 16'h4100, "R8");
        wr(1'b1, 16'h0100);
        chk_reg(1'b1, 16'h0000, "R8");
        chk_irq(2'b00, "R8");
        wr(1'b0, 16'h0000);
    endtask

    initial begin
        tick(3);
        @(negedge clk); rst_n = 1'b1;
        tick(1);
        t_reset();
        t_live_and_ctrl();
        t_card_detect();
        t_mem_pins();
        t_io_mode();
        t_timeout_collision();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end
endmodule